// File: doc/BRIEF.md
# Freeze Bridge Control Unit

This block sits next to a reconfigurable logic region and decides whether traffic may cross the region boundary. A host drives it through a small 32-bit register port with an address, a write strobe, write data, a read strobe and registered read data. A freeze request raises a blocking output at the boundary. The freeze is reported as complete once the region reports that its in-flight transfers have drained. An unfreeze request lowers the blocking output again. The block can also drive the region's reset while the region is frozen.

Completion is reported through two status flags that hold their value. The flags follow the state of the control machine, not the last write. A write to the control register that does not fit the current state is blocked: the offending request bits are not accepted, and they are recorded in a sticky illegal-request register that the host clears by writing a one. The traffic gating itself and the reconfiguration of the region are handled elsewhere.

Top module: `frz_bridge_ctl`

## Requirements
- R1: After reset the status reads 2 (bit 1 = unfreeze done set, bit 0 = freeze done clear). `freeze_o` and `region_rst_o` are low, and the control and illegal registers read 0.
- R2: A read at byte offset 12 returns the parameter `VERSION` (default 2).
- R3: A control write (byte offset 4) with bit 0 set while status bit 1 is set raises `freeze_o` one cycle after the write edge. Status stays 2 while `region_idle` stays low.
- R4: While a freeze is draining, the first clock edge that samples `region_idle` high makes status read 1. `freeze_o` stays high while frozen.
- R5: Writing 0 to control while a freeze is still draining withdraws it: `freeze_o` falls one cycle later and status stays 2.
- R6: Control bit 1 written while status bit 0 is set drives `region_rst_o` high from the cycle after the write edge. `freeze_o` stays high while it does.
- R7: Control bit 2 written while frozen lowers `freeze_o` and `region_rst_o` one cycle after the write edge, with status 0 in that cycle. Status reads 2 one cycle later.
- R8: Requesting the state already held (bit 0 while frozen, bit 2 while unfrozen) leaves the status unchanged and flags nothing.
- R9: A control write sets illegal-register bit n for each offending control bit n. Bit 1 offends when status bit 0 is clear. Bits 0 and 2 offend when both are written together, and each offends alone when status is 0 (unfreeze in progress). Offending bits are not accepted into control.
- R10: The illegal register (byte offset 8) holds its bits until a write with bit 0 set clears it. A write there with bit 0 clear changes nothing.
- R11: Control reads back the accepted request bits in [2:0], with higher bits zero. Addresses with bits [ADDR_W-1:4] nonzero read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe edge |
| region_idle | input | 1 | Region has no transfers in flight |
| freeze_o | output | 1 | Blocks traffic at the region boundary |
| region_rst_o | output | 1 | Reset to the region |
| stat_o | output | 2 | bit 0 freeze done, bit 1 unfreeze done |

## Verification
The hardest state to reach is the single-cycle window in which an unfreeze is under way and neither status flag is set. Only there does a lone freeze request count as illegal. The bench reaches it by writing the unfreeze request, leaving exactly one idle cycle, and then writing a freeze request. That write lands on the transition cycle and must be flagged and dropped. All eight control patterns are also swept from both the unfrozen and the frozen state, with reserved bits set. The expected illegal code and accepted bits are computed from the request bits.

// File: rtl/frz_pkg.sv
package frz_pkg;
   typedef enum logic [1:0] {ST_RUN, ST_DRAIN, ST_FROZEN, ST_THAW} frz_state_e;
   localparam int CTL_FRZ = 0;
   localparam int CTL_RST = 1;
   localparam int CTL_UNF = 2;
   localparam int CTL_W   = 3;
   localparam logic [1:0] SLOT_STAT = 2'd0;
   localparam logic [1:0] SLOT_CTRL = 2'd1;
   localparam logic [1:0] SLOT_ILL  = 2'd2;
   localparam logic [1:0] SLOT_VER  = 2'd3;
endpackage

// File: rtl/frz_fsm.sv
module frz_fsm
   import frz_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_frz,
   input  logic req_rst,
   input  logic req_unf,
   input  logic region_idle,
   output logic freeze_o,
   output logic region_rst_o,
   output logic done_frz,
   output logic done_unf
);
   frz_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:    if (req_frz) state_d = ST_DRAIN;
         ST_DRAIN:  if (!req_frz) state_d = ST_RUN;
                    else if (region_idle) state_d = ST_FROZEN;
         ST_FROZEN: if (req_unf) state_d = ST_THAW;
         ST_THAW:   state_d = ST_RUN;
         default:   state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   assign freeze_o     = (state_q == ST_DRAIN) || (state_q == ST_FROZEN);
   assign region_rst_o = (state_q == ST_FROZEN) && req_rst;
   assign done_frz     = (state_q == ST_FROZEN);
   assign done_unf     = (state_q == ST_RUN) || (state_q == ST_DRAIN);
endmodule

// File: rtl/frz_regs.sv
module frz_regs
   import frz_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] VERSION = 2,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              done_frz,
   input  logic              done_unf,
   output logic [CTL_W-1:0]  ctrl_o,
   output logic [CTL_W-1:0]  ill_o
);
   localparam int PAD_W = DATA_W - CTL_W;

   logic             hit;
   logic [1:0]       slot;
   logic [CTL_W-1:0] ctrl_q, ill_q, req, bad;
   logic [DATA_W-1:0] mux;
   logic             wr_ctrl, wr_ill, both_clear;

   generate
      if (ADDR_W > 4) begin : g_dec_hi
         assign hit = ~|bus_addr[ADDR_W-1:4];
      end else begin : g_dec_flat
         assign hit = 1'b1;
      end
   endgenerate

   assign slot    = bus_addr[3:2];
   assign wr_ctrl = bus_wr && hit && (slot == SLOT_CTRL);
   assign wr_ill  = bus_wr && hit && (slot == SLOT_ILL);
   assign req     = bus_wdata[CTL_W-1:0];
   assign both_clear = !done_frz && !done_unf;

   always_comb begin
      bad = '0;
      bad[CTL_FRZ] = req[CTL_FRZ] && (req[CTL_UNF] || both_clear);
      bad[CTL_UNF] = req[CTL_UNF] && (req[CTL_FRZ] || both_clear);
      bad[CTL_RST] = req[CTL_RST] && !done_frz;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ill_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= req & ~bad;
            ill_q  <= ill_q | bad;
         end else if (wr_ill && bus_wdata[0]) begin
            ill_q  <= '0;
         end
      end
   end

   always_comb begin
      mux = '0;
      if (hit) begin
         unique case (slot)
            SLOT_STAT: mux = {{(DATA_W-2){1'b0}}, done_unf, done_frz};
            SLOT_CTRL: mux = {{PAD_W{1'b0}}, ctrl_q};
            SLOT_ILL:  mux = {{PAD_W{1'b0}}, ill_q};
            SLOT_VER:  mux = VERSION;
            default:   mux = '0;
         endcase
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      rdata_q <= '0;
            else if (bus_rd) rdata_q <= mux;
            else             rdata_q <= '0;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? mux : '0;
      end
   endgenerate

   assign ctrl_o = ctrl_q;
   assign ill_o  = ill_q;
endmodule

// File: rtl/frz_bridge_ctl.sv
module frz_bridge_ctl
   import frz_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] VERSION = 2,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              region_idle,
   output logic              freeze_o,
   output logic              region_rst_o,
   output logic [1:0]        stat_o
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("frz_bridge_ctl: ADDR_W must be at least 4");
      end
      if (DATA_W < 32) begin : g_bad_data
         $error("frz_bridge_ctl: DATA_W must be at least 32");
      end
   endgenerate

   logic             done_frz, done_unf;
   logic [CTL_W-1:0] ctrl_vec, ill_vec;

   frz_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION), .READ_REG(READ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .done_frz(done_frz), .done_unf(done_unf),
      .ctrl_o(ctrl_vec), .ill_o(ill_vec)
   );

   frz_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_frz(ctrl_vec[CTL_FRZ]), .req_rst(ctrl_vec[CTL_RST]),
      .req_unf(ctrl_vec[CTL_UNF]), .region_idle(region_idle),
      .freeze_o(freeze_o), .region_rst_o(region_rst_o),
      .done_frz(done_frz), .done_unf(done_unf)
   );

   assign stat_o = {done_unf, done_frz};
endmodule

// File: rtl/frz_bridge_ctl_chk.sv
module frz_bridge_ctl_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              region_idle,
   input logic              freeze_o,
   input logic              region_rst_o,
   input logic [1:0]        stat_o,
   input logic [2:0]        ill_vec
);
   logic ill_clr_wr;
   assign ill_clr_wr = bus_wr && (bus_addr == ADDR_W'(8)) && bus_wdata[0];

   p_status_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o != 2'b11);
   p_frozen_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stat_o[0] |-> freeze_o);
   p_done_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[0]) |-> $past(region_idle));
   p_reset_only_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      region_rst_o |-> (stat_o == 2'b01) && freeze_o);
   p_thaw_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_o == 2'b00) |=> (stat_o == 2'b10) && !freeze_o);
   p_ill_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ill_vec) < $countones($past(ill_vec))) |-> $past(ill_clr_wr));
endmodule

bind frz_bridge_ctl frz_bridge_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .region_idle(region_idle), .freeze_o(freeze_o),
   .region_rst_o(region_rst_o), .stat_o(stat_o), .ill_vec(ill_vec)
);

// File: tb/frz_bridge_ctl_test.sv
module frz_bridge_ctl_test;
   localparam int AW = 6;
   localparam int DW = 32;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 0;
   logic [DW-1:0] bus_wdata = '0;
   logic          bus_rd = 0;
   logic [DW-1:0] bus_rdata;
   logic          region_idle = 0;
   logic          freeze_o, region_rst_o;
   logic [1:0]    stat_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   frz_bridge_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .region_idle(region_idle), .freeze_o(freeze_o),
      .region_rst_o(region_rst_o), .stat_o(stat_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(posedge clk); #1;
      bus_wr = 0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1;
      @(posedge clk); #1;
      d = bus_rdata;
      bus_rd = 0;
   endtask

   task automatic go_frozen();
      region_idle = 1;
      wr(6'd4, 32'd1);
      tick(); tick();
      region_idle = 0;
   endtask

   task automatic go_run();
      wr(6'd4, 32'd4);
      tick(); tick();
      wr(6'd4, 32'd0);
      wr(6'd8, 32'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 status", {30'd0, stat_o}, 32'd2);
      chk("R1 freeze", {31'd0, freeze_o}, 0);
      chk("R1 rst", {31'd0, region_rst_o}, 0);
      rd(6'd0, d); chk("R1 status read", d, 2);
      rd(6'd4, d); chk("R1 ctrl read", d, 0);
      rd(6'd8, d); chk("R1 ill read", d, 0);
      // R2 version
      rd(6'd12, d); chk("R2 version", d, 2);

      // R3 / R4 drain and completion
      wr(6'd4, 32'd1);
      chk("R3 freeze not yet", {31'd0, freeze_o}, 0);
      tick();
      chk("R3 freeze raised", {31'd0, freeze_o}, 1);
      repeat (4) tick();
      chk("R3 status while draining", {30'd0, stat_o}, 2);
      region_idle = 1;
      tick();
      chk("R4 status frozen", {30'd0, stat_o}, 1);
      chk("R4 freeze held", {31'd0, freeze_o}, 1);
      region_idle = 0;
      // R8 freeze while frozen
      wr(6'd4, 32'd1);
      tick();
      chk("R8 refreeze status", {30'd0, stat_o}, 1);
      rd(6'd8, d); chk("R8 refreeze ill", d, 0);
      // R6 region reset
      wr(6'd4, 32'd2);
      chk("R6 region reset", {31'd0, region_rst_o}, 1);
      chk("R6 freeze held", {31'd0, freeze_o}, 1);
      // R7 unfreeze
      wr(6'd4, 32'd4);
      tick();
      chk("R7 freeze dropped", {31'd0, freeze_o}, 0);
      chk("R7 reset dropped", {31'd0, region_rst_o}, 0);
      chk("R7 status mid", {30'd0, stat_o}, 0);
      tick();
      chk("R7 status done", {30'd0, stat_o}, 2);
      // R8 unfreeze while unfrozen
      wr(6'd4, 32'd4);
      tick();
      chk("R8 reunfreeze status", {30'd0, stat_o}, 2);
      rd(6'd8, d); chk("R8 reunfreeze ill", d, 0);

      // R5 withdraw
      wr(6'd4, 32'd1);
      tick();
      chk("R5 draining", {31'd0, freeze_o}, 1);
      wr(6'd4, 32'd0);
      tick();
      chk("R5 withdrawn freeze", {31'd0, freeze_o}, 0);
      chk("R5 withdrawn status", {30'd0, stat_o}, 2);

      // R9 R11 sweep from unfrozen state, reserved bits set
      for (int v = 0; v < 8; v++) begin
         logic [2:0] vb, bad, acc;
         vb = 3'(v);
         bad[0] = vb[0] & vb[2];
         bad[2] = vb[0] & vb[2];
         bad[1] = vb[1];
         acc = vb & ~bad;
         wr(6'd4, 32'hFFFF_FFF8 | 32'(v));
         tick();
         chk("R9 run sweep freeze", {31'd0, freeze_o}, {31'd0, acc[0]});
         chk("R9 run sweep rst", {31'd0, region_rst_o}, 0);
         rd(6'd8, d); chk("R9 run sweep ill", d, {29'd0, bad});
         rd(6'd4, d); chk("R11 run sweep ctrl", d, {29'd0, acc});
         wr(6'd4, 32'd0);
         tick();
         wr(6'd8, 32'd2);
         rd(6'd8, d); chk("R10 zero write keeps", d, {29'd0, bad});
         wr(6'd8, 32'd1);
         rd(6'd8, d); chk("R10 clear", d, 0);
         chk("R9 run sweep back", {30'd0, stat_o}, 2);
      end

      // R9 sweep from frozen state
      for (int v = 0; v < 8; v++) begin
         logic [2:0] vb, bad, acc;
         vb = 3'(v);
         bad = 3'b000;
         bad[0] = vb[0] & vb[2];
         bad[2] = vb[0] & vb[2];
         acc = vb & ~bad;
         go_frozen();
         wr(6'd8, 32'd1);
         wr(6'd4, 32'hFFFF_FFF8 | 32'(v));
         chk("R6 frozen sweep rst", {31'd0, region_rst_o}, {31'd0, acc[1]});
         tick();
         chk("R7 frozen sweep freeze", {31'd0, freeze_o}, {31'd0, !acc[2]});
         tick();
         chk("R7 frozen sweep status", {30'd0, stat_o}, acc[2] ? 32'd2 : 32'd1);
         rd(6'd8, d); chk("R9 frozen sweep ill", d, {29'd0, bad});
         rd(6'd4, d); chk("R11 frozen sweep ctrl", d, {29'd0, acc});
         go_run();
         chk("R7 frozen sweep restore", {30'd0, stat_o}, 2);
      end

      // R9 freeze request landing in the unfreeze transition cycle
      go_frozen();
      wr(6'd4, 32'd4);
      tick();
      wr(6'd4, 32'd1);
      rd(6'd8, d); chk("R9 mid-thaw freeze ill", d, 1);
      rd(6'd4, d); chk("R9 mid-thaw ctrl", d, 0);
      chk("R9 mid-thaw freeze_o", {31'd0, freeze_o}, 0);
      chk("R9 mid-thaw status", {30'd0, stat_o}, 2);
      wr(6'd8, 32'd1);

      // R11 unmapped addresses
      for (int a = 16; a < 64; a += 4) begin
         wr(6'(a), 32'd1);
         tick();
         chk("R11 unmapped write", {31'd0, freeze_o}, 0);
         rd(6'(a), d); chk("R11 unmapped read", d, 0);
      end
      rd(6'd4, d); chk("R11 ctrl untouched", d, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule